// File: doc/BRIEF.md
# Mask Register Renamer

This block maps each write to one of eight architectural predicate-mask registers onto a fresh entry of a private 142-entry physical mask file. It owns an alias table, a committed-state copy of that table and a circular free list of physical tags. None of these is shared with the integer or vector rename pools. One mask-writing micro-op per cycle presents two architectural sources and one destination. The block answers in the same cycle with the physical tags of both sources, a newly allocated destination tag and the tag that the destination held before, which the micro-op carries until it retires.

Register-to-register mask copies and xor operations whose two sources are the same register get no special treatment. Each one allocates its own destination and reports true source tags, so downstream scheduling keeps the dependency. A retiring micro-op returns its previous destination tag to the tail of the free list and updates the committed map. A flush pulse copies the committed map back into the alias table. It then rebuilds the free list by scanning every physical tag once, and rename stalls while the scan runs.

Top module: `mask_rename`

## Requirements
- R1: After reset, architectural register i maps to physical tag i for i in 0..7, rename is not stalled, and the free list holds tags 8 through 141 in ascending order.
- R2: An accepted rename (renValid high, renStall low) takes exactly one tag from the head of the free list as renDstTag, and successive accepted renames receive successive free-list entries.
- R3: An accepted rename updates the alias table at the clock edge. Later renames that read that architectural register see the new tag, while the same micro-op's source tags show the mapping from before its own write.
- R4: A copy or a self-xor (both sources equal) allocates a destination tag that differs from its source tags, and its source tags equal the current mapping. renOldTag equals the destination's mapping from before the write.
- R5: renStall is high whenever the free list is empty, and a rename presented while stalled changes neither the alias table nor the free list.
- R6: A retire returns retOldTag to the tail of the free list. A rename that is stalled in the same cycle as that retire stays stalled, and the freed tag is handed out after every tag already in the list.
- R7: A retire writes retNewTag into the committed map entry of retArch.
- R8: In the cycle flush is high, and for the 142 cycles after it, renStall is high. After that, the alias table equals the committed map and the free list holds, in ascending order, every tag that the committed map does not reference.
- R9: A retire presented in the flush cycle or during the rebuild that follows it is ignored.
- R10: The free-list occupancy never exceeds 134, the number of speculative entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Restore the alias table from the committed map and rebuild the free list |
| renValid | input | 1 | A mask-writing micro-op is offered for rename |
| renSrcA | input | 3 | First architectural source |
| renSrcB | input | 3 | Second architectural source |
| renDst | input | 3 | Architectural destination |
| renStall | output | 1 | Rename cannot accept this cycle |
| renSrcTagA | output | 8 | Physical tag of renSrcA |
| renSrcTagB | output | 8 | Physical tag of renSrcB |
| renDstTag | output | 8 | Newly allocated physical tag for renDst |
| renOldTag | output | 8 | Tag that renDst held before this rename |
| retValid | input | 1 | A micro-op retires |
| retArch | input | 3 | Architectural destination of the retiring micro-op |
| retNewTag | input | 8 | Tag it allocated, now committed |
| retOldTag | input | 8 | Tag it displaced, to be freed |

## Verification
Directed self-xor and copy micro-ops show whether the renamer gives these operations a fresh destination and keeps their source tags, rather than aliasing or zeroing them. A burst of renames with no retirement drains the free list and shows where the stall begins. A retire offered in that same stalled cycle tells the tail-push apart from any bypass to the head. A flush after partial retirement, with stray retires offered during the rebuild, separates the restored committed state from leftover speculative state. A long random mix of renames, retires, self-xors and repeated destinations, checked against a queue model, exercises pointer wrap-around and the ordering of recycled tags.

// File: rtl/mask_rename_pkg.sv
package mask_rename_pkg;
  localparam int NUM_ARCH   = 8;
  localparam int NUM_PHYS   = 142;
  localparam int ARCH_W     = $clog2(NUM_ARCH);
  localparam int TAG_W      = $clog2(NUM_PHYS);
  localparam int FREE_DEPTH = NUM_PHYS - NUM_ARCH;
  localparam int PTR_W      = $clog2(FREE_DEPTH);
  localparam int CNT_W      = $clog2(FREE_DEPTH + 1);

  typedef logic [TAG_W-1:0]  tag_t;
  typedef logic [ARCH_W-1:0] arch_t;

  // strobes from control to datapath
  typedef struct packed {
    logic alloc;      // accepted rename: pop head, write alias table
    logic retire;     // push old tag, update committed map
    logic restore;    // copy committed map into alias table, empty the list
    logic scanValid;  // rebuild scan is offering scanTag
    tag_t scanTag;
  } strobe_t;
endpackage

// File: rtl/mask_rename_ctrl.sv
module mask_rename_ctrl
  import mask_rename_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    flush,
  input  logic    renValid,
  input  logic    retValid,
  input  logic    freeEmpty,
  output logic    renStall,
  output strobe_t strb
);
  logic rebuilding;
  tag_t scanTag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rebuilding <= 1'b0;
      scanTag    <= '0;
    end else if (flush) begin
      rebuilding <= 1'b1;
      scanTag    <= '0;
    end else if (rebuilding) begin
      if (scanTag == tag_t'(NUM_PHYS - 1)) rebuilding <= 1'b0;
      scanTag <= scanTag + 1'b1;
    end
  end

  always_comb begin
    renStall       = flush | rebuilding | freeEmpty;
    strb.alloc     = renValid & ~renStall;
    strb.retire    = retValid & ~flush & ~rebuilding;
    strb.restore   = flush;
    strb.scanValid = rebuilding;
    strb.scanTag   = scanTag;
  end
endmodule

// File: rtl/mask_rename_data.sv
module mask_rename_data
  import mask_rename_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  strobe_t          strb,
  input  arch_t            renSrcA,
  input  arch_t            renSrcB,
  input  arch_t            renDst,
  input  arch_t            retArch,
  input  tag_t             retNewTag,
  input  tag_t             retOldTag,
  output tag_t             srcTagA,
  output tag_t             srcTagB,
  output tag_t             dstTag,
  output tag_t             oldTag,
  output logic             freeEmpty,
  output logic [CNT_W-1:0] freeCount
);
  tag_t aliasMap  [NUM_ARCH];
  tag_t commitMap [NUM_ARCH];
  tag_t freeQ     [FREE_DEPTH];
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [NUM_ARCH-1:0] scanHit;
  logic pushEn;
  tag_t pushTag;

  // a scanned tag is free unless some committed entry points at it
  for (genvar g = 0; g < NUM_ARCH; g++) begin : g_hit
    assign scanHit[g] = (commitMap[g] == strb.scanTag);
  end

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(FREE_DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    srcTagA   = aliasMap[renSrcA];
    srcTagB   = aliasMap[renSrcB];
    oldTag    = aliasMap[renDst];
    dstTag    = freeQ[headPtr];
    freeEmpty = (freeCount == '0);
    pushEn    = strb.retire | (strb.scanValid & ~(|scanHit));
    pushTag   = strb.retire ? retOldTag : strb.scanTag;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_ARCH; i++) begin
        aliasMap[i]  <= tag_t'(i);
        commitMap[i] <= tag_t'(i);
      end
      for (int j = 0; j < FREE_DEPTH; j++) freeQ[j] <= tag_t'(j + NUM_ARCH);
      headPtr   <= '0;
      tailPtr   <= '0;
      freeCount <= CNT_W'(FREE_DEPTH);
    end else if (strb.restore) begin
      for (int i = 0; i < NUM_ARCH; i++) aliasMap[i] <= commitMap[i];
      headPtr   <= '0;
      tailPtr   <= '0;
      freeCount <= '0;
    end else begin
      if (strb.alloc) begin
        aliasMap[renDst] <= freeQ[headPtr];
        headPtr          <= nextPtr(headPtr);
      end
      if (strb.retire) commitMap[retArch] <= retNewTag;
      if (pushEn) begin
        freeQ[tailPtr] <= pushTag;
        tailPtr        <= nextPtr(tailPtr);
      end
      case ({strb.alloc, pushEn})
        2'b10:   freeCount <= freeCount - 1'b1;
        2'b01:   freeCount <= freeCount + 1'b1;
        default: freeCount <= freeCount;
      endcase
    end
  end
endmodule

// File: rtl/mask_rename.sv
module mask_rename
  import mask_rename_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       renValid,
  input  logic [2:0] renSrcA,
  input  logic [2:0] renSrcB,
  input  logic [2:0] renDst,
  output logic       renStall,
  output logic [7:0] renSrcTagA,
  output logic [7:0] renSrcTagB,
  output logic [7:0] renDstTag,
  output logic [7:0] renOldTag,
  input  logic       retValid,
  input  logic [2:0] retArch,
  input  logic [7:0] retNewTag,
  input  logic [7:0] retOldTag
);
  strobe_t          strb;
  logic             freeEmpty;
  logic [CNT_W-1:0] freeCount;

  mask_rename_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .flush(flush), .renValid(renValid),
    .retValid(retValid), .freeEmpty(freeEmpty), .renStall(renStall), .strb(strb)
  );

  mask_rename_data u_data (
    .clk(clk), .rst_n(rst_n), .strb(strb),
    .renSrcA(renSrcA), .renSrcB(renSrcB), .renDst(renDst),
    .retArch(retArch), .retNewTag(retNewTag), .retOldTag(retOldTag),
    .srcTagA(renSrcTagA), .srcTagB(renSrcTagB), .dstTag(renDstTag), .oldTag(renOldTag),
    .freeEmpty(freeEmpty), .freeCount(freeCount)
  );
endmodule

// File: rtl/mask_rename_chk.sv
module mask_rename_chk
  import mask_rename_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             renValid,
  input logic             renStall,
  input logic [7:0]       renSrcTagA,
  input logic [7:0]       renSrcTagB,
  input logic [7:0]       renDstTag,
  input logic [7:0]       renOldTag,
  input strobe_t          strb,
  input logic [CNT_W-1:0] freeCount
);
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    freeCount <= CNT_W'(FREE_DEPTH));

  a_r5_stall_on_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (freeCount == '0) |-> renStall);

  a_r2_one_per_alloc: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.alloc && !strb.retire && !strb.scanValid) |=>
      (freeCount == $past(freeCount) - 1'b1));

  a_r6_retire_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.retire && !strb.alloc) |=> (freeCount == $past(freeCount) + 1'b1));

  a_r4_fresh_dst: assert property (@(posedge clk) disable iff (!rst_n)
    (renValid && !renStall) |->
      (renDstTag != renOldTag && renDstTag != renSrcTagA && renDstTag != renSrcTagB));

  a_r8_flush_stall: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> renStall);
endmodule

bind mask_rename mask_rename_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .renValid(renValid), .renStall(renStall),
  .renSrcTagA(renSrcTagA), .renSrcTagB(renSrcTagB), .renDstTag(renDstTag),
  .renOldTag(renOldTag), .strb(strb), .freeCount(freeCount)
);

// File: tb/mask_rename_bench.sv
`timescale 1ns/1ps
module mask_rename_bench;
  localparam int NARCH = 8;
  localparam int NPHYS = 142;

  logic clk = 1'b0;
  logic rst_n, flush, renValid, retValid, renStall;
  logic [2:0] renSrcA, renSrcB, renDst, retArch;
  logic [7:0] renSrcTagA, renSrcTagB, renDstTag, renOldTag, retNewTag, retOldTag;

  always #4 clk = ~clk;

  mask_rename u_mask_rename (
    .clk(clk), .rst_n(rst_n), .flush(flush), .renValid(renValid),
    .renSrcA(renSrcA), .renSrcB(renSrcB), .renDst(renDst), .renStall(renStall),
    .renSrcTagA(renSrcTagA), .renSrcTagB(renSrcTagB), .renDstTag(renDstTag),
    .renOldTag(renOldTag), .retValid(retValid), .retArch(retArch),
    .retNewTag(retNewTag), .retOldTag(retOldTag)
  );

  typedef struct { int arch; int newT; int oldT; } flight_t;

  int checks = 0;
  int failures = 0;
  int modelRat [NARCH];
  int modelCommit [NARCH];
  int freeQ [$];
  flight_t inflight [$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bool_in_commit(input int t);
    for (int i = 0; i < NARCH; i++) if (modelCommit[i] == t) return 1;
    return 0;
  endfunction

  task automatic idle();
    renValid = 0; retValid = 0; flush = 0;
    renSrcA = 0; renSrcB = 0; renDst = 0;
    retArch = 0; retNewTag = 0; retOldTag = 0;
  endtask

  // one cycle: optional rename and optional retire of the oldest in-flight op
  task automatic step(input bit ren, input int a, input int b, input int d,
                      input bit ret, input string req);
    flight_t r;
    bit expStall;
    int t;
    @(negedge clk);
    renValid = ren; renSrcA = 3'(a); renSrcB = 3'(b); renDst = 3'(d);
    retValid = ret;
    if (ret) begin
      r = inflight.pop_front();
      retArch = 3'(r.arch); retNewTag = 8'(r.newT); retOldTag = 8'(r.oldT);
    end
    #1;
    expStall = (freeQ.size() == 0);
    if (ren) begin
      check(renStall == expStall, req, "stall", int'(renStall), int'(expStall));
      if (!expStall) begin
        check(renSrcTagA == modelRat[a], req, "srcTagA", renSrcTagA, modelRat[a]);
        check(renSrcTagB == modelRat[b], req, "srcTagB", renSrcTagB, modelRat[b]);
        check(renDstTag == freeQ[0], req, "dstTag", renDstTag, freeQ[0]);
        check(renOldTag == modelRat[d], req, "oldTag", renOldTag, modelRat[d]);
      end
    end
    @(posedge clk);
    if (ren && !expStall) begin
      t = freeQ.pop_front();
      inflight.push_back('{d, t, modelRat[d]});
      modelRat[d] = t;
    end
    if (ret) begin
      modelCommit[r.arch] = r.newT;
      freeQ.push_back(r.oldT);
    end
  endtask

  task automatic checkMap(input string req);
    @(negedge clk);
    idle();
    for (int a = 0; a < NARCH; a++) begin
      renSrcA = 3'(a);
      #1;
      check(renSrcTagA == modelRat[a], req, "map", renSrcTagA, modelRat[a]);
    end
  endtask

  task automatic doFlush();
    @(negedge clk);
    flush = 1; renValid = 1; renDst = 3'd4;
    retValid = 1; retArch = 3'd0; retNewTag = 8'd77; retOldTag = 8'd5;  // R9: ignored
    #1;
    check(renStall == 1'b1, "R8", "stall in flush cycle", renStall, 1);
    @(posedge clk);
    for (int i = 0; i < NARCH; i++) modelRat[i] = modelCommit[i];
    freeQ.delete();
    for (int t = 0; t < NPHYS; t++) if (!bool_in_commit(t)) freeQ.push_back(t);
    inflight.delete();
    for (int k = 0; k < NPHYS; k++) begin
      @(negedge clk);
      idle();
      if (k == 5) begin  // R9: retire during rebuild is ignored
        retValid = 1; retArch = 3'd2; retNewTag = 8'd9; retOldTag = 8'd3;
      end
      renValid = 1;
      #1;
      check(renStall == 1'b1, "R8", "stall during rebuild", renStall, 1);
    end
    @(negedge clk);
    idle();
    #1;
    check(renStall == 1'b0, "R8", "stall after rebuild", renStall, 0);
    checkMap("R7/R8/R9");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    for (int i = 0; i < NARCH; i++) begin modelRat[i] = i; modelCommit[i] = i; end
    for (int t = NARCH; t < NPHYS; t++) freeQ.push_back(t);

    // R1: reset mapping and not stalled
    #1;
    check(renStall == 1'b0, "R1", "stall after reset", renStall, 0);
    checkMap("R1");

    step(1, 1, 1, 1, 0, "R4 self-xor");   // dst 8, sources 1
    step(1, 2, 2, 3, 0, "R4 copy");       // dst 9
    step(1, 1, 3, 5, 0, "R3");            // sources 8 and 9
    step(1, 5, 5, 5, 0, "R3 R4 self-xor on renamed reg");

    // R2/R5: drain the free list without retiring
    while (freeQ.size() > 0)
      step(1, $urandom % 8, $urandom % 8, $urandom % 8, 0, "R2");
    step(1, 0, 1, 2, 0, "R5 stalled on empty");
    checkMap("R5 ignored while stalled");
    step(1, 0, 1, 2, 1, "R6 retire same cycle stays stalled");
    step(1, 3, 4, 6, 0, "R6 freed tag reissued");
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, "R6");
    step(1, 7, 6, 0, 0, "R6 order after retires");

    // R7/R8/R9: flush back to committed state
    doFlush();

    // random mix over wrap-around
    for (int n = 0; n < 3000; n++) begin
      bit ren, ret;
      int a;
      ren = ($urandom % 4) != 0;
      ret = (inflight.size() > 0) && (($urandom % 3) == 0);
      a = $urandom % 8;
      step(ren, a, ($urandom % 2) ? a : ($urandom % 8), $urandom % 8, ret, "R2/R3/R6");
    end

    doFlush();
    for (int n = 0; n < 300; n++)
      step(1, $urandom % 8, $urandom % 8, $urandom % 8,
           (inflight.size() > 0) && (($urandom % 2) == 0), "R2/R6 after flush");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule